// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of a configurable width using a single one-bit full adder and one carry flip-flop, working through the operands one bit per clock. The lowest-order bit goes first. A load strobe captures both operands in parallel into their own shift registers, clears the stored carry and restarts the bit counter. On each following clock, the full adder combines the two lowest operand bits with the stored carry. The sum bit is shifted into the top of a result register, the new carry is stored, and both operand registers move down by one position.

After exactly `WIDTH` shift clocks, a done flag pulses for one cycle. The result register then holds the low `WIDTH` bits of the sum and the carry flip-flop holds the carry out. Both stay unchanged until the next load. If a load arrives while an addition is running, that addition is dropped and a new one starts with the fresh operands. A synchronous active-high reset clears the carry, the result and the sequencing state.

Top module: `serial_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_o` is 0, `sum_o` is all zeros and `carry_o` is 0.
- R2: When `done_o` is 1, `{carry_o, sum_o}` equals the (WIDTH+1)-bit unsigned sum of the `op_a_i` and `op_b_i` values captured by the most recent load.
- R3: `done_o` is 1 in exactly one cycle: the cycle that follows the WIDTH-th rising edge after the edge that sampled `load_i` high. It is 0 in every other cycle.
- R4: A load clears the stored carry, so a carry left over from an earlier addition does not change the next result. For example, 0xFF + 0x01 followed by 0x00 + 0x00 gives 0 with carry 0.
- R5: A load sampled while an addition is running abandons it. No done pulse appears for the abandoned addition, and the result reflects only the new operands.
- R6: After the done cycle, and while no load occurs, `sum_o` and `carry_o` keep their values.
- R7: A carry that ripples through every bit position is handled correctly. For example, all ones + 1 gives all zeros with carry 1.
- R8: Reset asserted during an addition abandons it: no done pulse follows, and the outputs read zero until the next load completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture operands and start an addition |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Parallel result, low WIDTH bits of the sum |
| carry_o | output | 1 | Carry out of the most significant bit |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
On every cycle, the checker compares the done pulse against its own count of edges since the last load, tests the reported sum against the operands it captured at that load, and confirms that the outputs stay still after done and read zero after reset. Three behaviours need the directed scenarios to exercise them: clearing a leftover carry, a full-width carry ripple, and abandoning an addition through a new load or through reset. The checker holds only across whatever stimulus actually reaches it, so these cases have to be driven on purpose.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef enum logic {
        SA_IDLE = 1'b0,
        SA_RUN  = 1'b1
    } sa_state_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // one-bit full adder used by the serial datapath
    function automatic fa_out_t full_add(input logic a, input logic b, input logic ci);
        fa_out_t r;
        r.sum   = a ^ b ^ ci;
        r.carry = (a & b) | (ci & (a ^ b));
        return r;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sa_operand_shifter.sv
module sa_operand_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             lsb_o
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end

    assign lsb_o = q[0];
endmodule

// File: rtl/sa_sum_shifter.sv
module sa_sum_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= '0;
        end else if (shift) begin
            q <= {bit_in, q[WIDTH-1:1]};
        end
    end

    assign q_o = q;
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
    import serial_add_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic shift_o,
    output logic done_o
);
    localparam int unsigned CNT_W = cnt_bits(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    sa_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SA_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                state <= SA_RUN;
                cnt   <= '0;
            end else if (state == SA_RUN) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    state  <= SA_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign shift_o = (state == SA_RUN) && !load;
    assign done_o  = done_q;
endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import serial_add_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             done_o
);
    localparam int unsigned N_OPS = 2;

    logic [WIDTH-1:0] op_in [N_OPS];
    logic [N_OPS-1:0] op_bit;
    logic             shift;
    logic             carry_q;
    fa_out_t          fa;

    assign op_in[0] = op_a_i;
    assign op_in[1] = op_b_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        sa_operand_shifter #(.WIDTH(WIDTH)) i_shr (
            .clk   (clk),
            .rst   (rst),
            .load  (load_i),
            .shift (shift),
            .din   (op_in[g]),
            .lsb_o (op_bit[g])
        );
    end

    sa_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .shift_o (shift),
        .done_o  (done_o)
    );

    assign fa = full_add(op_bit[0], op_bit[1], carry_q);

    // carry flip-flop: cleared on load, updated on every shift clock
    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            carry_q <= 1'b0;
        end else if (shift) begin
            carry_q <= fa.carry;
        end
    end

    sa_sum_shifter #(.WIDTH(WIDTH)) i_sum (
        .clk    (clk),
        .rst    (rst),
        .clear  (load_i),
        .shift  (shift),
        .bit_in (fa.sum),
        .q_o    (sum_o)
    );

    assign carry_o = carry_q;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [WIDTH-1:0] op_a_i,
    input logic [WIDTH-1:0] op_b_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             done_o
);
    localparam int unsigned EW = $clog2(WIDTH + 2);
    localparam logic [EW-1:0] DUE = EW'(WIDTH);

    logic          run;
    logic [EW-1:0] edges;
    logic [WIDTH:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            edges <= '0;
            want  <= '0;
        end else if (load_i) begin
            run   <= 1'b1;
            edges <= '0;
            want  <= {1'b0, op_a_i} + {1'b0, op_b_i};
        end else if (run) begin
            if (edges == DUE) begin
                run <= 1'b0;
            end else begin
                edges <= edges + 1'b1;
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done_o && sum_o == '0 && !carry_o));

    a_r2_sum_matches: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ({carry_o, sum_o} == want));

    a_r3_done_on_time: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run && edges == DUE));

    a_r3_done_not_missed: assert property (@(posedge clk) disable iff (rst)
        (run && edges == DUE) |-> done_o);

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r6_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> ($stable(sum_o) && $stable(carry_o)));
endmodule

bind serial_adder serial_adder_chk #(.WIDTH(WIDTH)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .done_o  (done_o)
);

// File: tb/test_serial_adder.sv
`timescale 1ns/1ps
module test_serial_adder;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] op_a_i = '0;
    logic [W-1:0] op_b_i = '0;
    logic [W-1:0] sum_o;
    logic         carry_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_adder #(.WIDTH(W)) i_serial_adder (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .op_a_i  (op_a_i),
        .op_b_i  (op_b_i),
        .sum_o   (sum_o),
        .carry_o (carry_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load_i = 1'b1;
        op_a_i = a;
        op_b_i = b;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // waits out the addition started by pulse_load, checks timing and value
    task automatic finish_add(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W:0] exp;
        int early;
        exp = {1'b0, a} + {1'b0, b};
        early = 0;
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            if (done_o) early++;
        end
        check(early == 0, "R3 no early done", early, 0);
        @(negedge clk);
        check(done_o == 1'b1, "R3 done after WIDTH clocks", done_o, 1);
        check({carry_o, sum_o} == exp, req, {carry_o, sum_o}, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R3 done lasts one cycle", done_o, 0);
        check({carry_o, sum_o} == exp, "R6 result held", {carry_o, sum_o}, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!done_o && sum_o == '0 && !carry_o, "R1 reset state", {done_o, carry_o, sum_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o && sum_o == '0 && !carry_o, "R1 after reset", {done_o, carry_o, sum_o}, 0);
    endtask

    task automatic t_basic;
        pulse_load(8'h23, 8'h45); finish_add(8'h23, 8'h45, "R2 sum 23+45");
        pulse_load(8'hA5, 8'h5A); finish_add(8'hA5, 8'h5A, "R2 sum A5+5A");
        pulse_load(8'hC8, 8'h9E); finish_add(8'hC8, 8'h9E, "R2 sum with carry out");
    endtask

    task automatic t_ripple;
        pulse_load(8'hFF, 8'h01); finish_add(8'hFF, 8'h01, "R7 full ripple FF+01");
        pulse_load(8'hFF, 8'hFF); finish_add(8'hFF, 8'hFF, "R7 FF+FF");
    endtask

    task automatic t_carry_clear;
        pulse_load(8'h80, 8'h80); finish_add(8'h80, 8'h80, "R4 first add with carry");
        pulse_load(8'h00, 8'h00); finish_add(8'h00, 8'h00, "R4 stale carry cleared");
    endtask

    task automatic t_hold;
        pulse_load(8'h3C, 8'h0F); finish_add(8'h3C, 8'h0F, "R2 sum 3C+0F");
        repeat (5) @(negedge clk);
        check({carry_o, sum_o} == 9'h04B, "R6 held long after done", {carry_o, sum_o}, 9'h04B);
    endtask

    task automatic t_abort;
        int seen;
        pulse_load(8'h11, 8'h22);
        seen = 0;
        repeat (3) begin
            @(negedge clk);
            if (done_o) seen++;
        end
        pulse_load(8'h7F, 8'h90);
        check(seen == 0, "R5 no done for aborted add", seen, 0);
        finish_add(8'h7F, 8'h90, "R5 restarted result");
    endtask

    task automatic t_reset_mid;
        int seen;
        pulse_load(8'hF0, 8'h33);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seen = 0;
        for (int i = 0; i < W + 3; i++) begin
            @(negedge clk);
            if (done_o) seen++;
        end
        check(seen == 0, "R8 no done after reset", seen, 0);
        check(sum_o == '0 && !carry_o, "R8 outputs cleared", {carry_o, sum_o}, 0);
        pulse_load(8'h12, 8'h34); finish_add(8'h12, 8'h34, "R8 add after reset");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_ripple();
        t_carry_clear();
        t_hold();
        t_abort();
        t_reset_mid();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule